// File: doc/BRIEF.md
# Soft-Start and Fault Shutdown Sequencer

This block sits in front of a phase-shifted bridge PWM generator. It decides when the PWM generator may drive its outputs. It also limits the duty command while the converter is powering up or backing off. It does not contain any comparators. It receives the digitized supply level, the duty command, a reference-good flag, an external disable flag and an overcurrent flag, and it derives everything else from these.

A saturating soft-start level rises by a programmable step on every clock. The duty command passed to the PWM generator is the smaller of the incoming command and this level. The supply check uses separate start and stop thresholds. A no-load check with its own hysteresis turns the outputs off when the duty command is very small.

Two kinds of fault are handled differently:
- **Loss of supply or reference, or an external disable:** the level drops to zero at once.
- **Overcurrent:** the block runs a soft stop. The level falls at ten times the programmed rate until it drops under a fixed floor. A full soft start then follows from wherever the level stopped.

Top module: `soft_start_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `state_o` is 0 (OFF), and `level_o`, `duty_o` and `out_en` are 0.
- R2: The supply-good flag sets on a clock where `sup_lvl` >= 110. It clears on a clock where `sup_lvl` < 90. Between these thresholds it keeps its value. It reaches `state_o` one clock later. While it is clear, the block stays in OFF.
- R3: If the supply-good flag or `ref_ok` is low at a clock edge, that edge moves the block to OFF (0) with `level_o` = 0. OFF moves to SOFT_START (1) on the first edge that sees power good.
- R4: `dis_req` high at an edge (with power good) moves the block to DISABLED (4) with `level_o` = 0. The first edge with `dis_req` low moves DISABLED to SOFT_START with the level still 0.
- R5: In SOFT_START, each edge adds `step` to the level, saturating at 255. The edge that makes the level 255 also moves the state to RUN (2). RUN holds 255.
- R6: `oc_flag` high at an edge in SOFT_START or RUN moves the block to SOFT_STOP (3). The level is left unchanged on that edge.
- R7: In SOFT_STOP, an edge with the level >= 26 subtracts 10*`step`, floored at 0. An edge with the level < 26 moves the block to SOFT_START and keeps the level. `oc_flag` has no effect in SOFT_STOP.
- R8: The conditions are ranked. Supply or reference loss (to OFF) overrides `dis_req` (to DISABLED), and `dis_req` overrides `oc_flag`.
- R9: `duty_o` always equals min(`duty_in`, `level_o`), combinationally.
- R10: A no-load flag sets on an edge with `duty_in` > 31 and clears on an edge with `duty_in` < 26. `out_en` is this flag ANDed with state SOFT_START or RUN.
- R11: With `step` = 0, the level holds still in SOFT_START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_lvl | input | 8 | Digitized supply level |
| ref_ok | input | 1 | Reference within range |
| dis_req | input | 1 | External disable request |
| oc_flag | input | 1 | Overcurrent detected |
| step | input | 4 | Soft-start increment per clock |
| duty_in | input | 8 | Duty command from the error path |
| state_o | output | 3 | Sequencer state code |
| level_o | output | 8 | Soft-start level |
| duty_o | output | 8 | Clamped duty command |
| out_en | output | 1 | PWM output enable |

## Verification
Overcurrent and disable, or overcurrent and reference loss, can arrive on the same edge. The bench provokes this by raising `oc_flag` and `dis_req` together while the block is in RUN. It then drops `ref_ok` while the disable is still held. Each result must follow the R8 ranking: DISABLED with a zero level, then OFF.

A second collision happens at the end of a soft stop. There, `oc_flag` is still high on the edges that are decrementing the level. The bench checks that every step equals the arithmetic 10*step decrement and that the flag never restarts the stop.

// File: rtl/ss_seq_pkg.sv
// Shared state encoding for the soft-start sequencer.
// Assumes: state codes are visible at the top-level state output.
package ss_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF        = 3'd0,
        ST_SOFT_START = 3'd1,
        ST_RUN        = 3'd2,
        ST_SOFT_STOP  = 3'd3,
        ST_DISABLED   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/ss_hyst.sv
// Registered hysteresis comparator on an unsigned level.
// Sets when val >= SET_TH, clears when val < CLR_TH, otherwise holds.
// Assumes: CLR_TH <= SET_TH, both representable in W bits.
module ss_hyst #(
    parameter int W      = 8,
    parameter int SET_TH = 110,
    parameter int CLR_TH = 90
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val,
    output logic         on
);
    localparam logic [W-1:0] SET_V = W'(SET_TH);
    localparam logic [W-1:0] CLR_V = W'(CLR_TH);

    // Update the flag with a dead band between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            on <= 1'b0;
        else if (!on && (val >= SET_V))
            on <= 1'b1;
        else if (on && (val < CLR_V))
            on <= 1'b0;
    end
endmodule

// File: rtl/ss_seq_core.sv
// Sequencer state machine plus the soft-start level register.
// Ramp up by step, ramp down by FAST_MUL*step during a soft stop,
// and force the level to zero on power loss or disable.
// Assumes: pwr_ok already combines supply hysteresis and reference flag.
module ss_seq_core
    import ss_seq_pkg::*;
#(
    parameter int LVL_W    = 8,
    parameter int STEP_W   = 4,
    parameter int FAST_MUL = 10,
    parameter int FLOOR    = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              dis_req,
    input  logic              oc_flag,
    input  logic [STEP_W-1:0] step,
    output seq_state_e        state,
    output logic [LVL_W-1:0]  level
);
    localparam int FAST_W = STEP_W + $clog2(FAST_MUL + 1);
    localparam int CW     = ((LVL_W > FAST_W) ? LVL_W : FAST_W) + 1;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [LVL_W-1:0] FLOOR_V = LVL_W'(FLOOR);

    logic [CW-1:0]    lvl_ext, up_sum, dn_amt, dn_diff;
    logic [LVL_W-1:0] lvl_up, lvl_dn;

    // Saturating increment and floored decrement of the level.
    always_comb begin
        lvl_ext = CW'(level);
        up_sum  = lvl_ext + CW'(step);
        dn_amt  = CW'(step) * CW'(FAST_MUL);
        dn_diff = lvl_ext - dn_amt;
        lvl_up  = (up_sum > CW'(LVL_MAX)) ? LVL_MAX : up_sum[LVL_W-1:0];
        lvl_dn  = (lvl_ext < dn_amt) ? '0 : dn_diff[LVL_W-1:0];
    end

    // Ranked transitions: power loss, then disable, then per-state rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            level <= '0;
        end else if (!pwr_ok) begin
            state <= ST_OFF;
            level <= '0;
        end else if (dis_req) begin
            state <= ST_DISABLED;
            level <= '0;
        end else begin
            case (state)
                ST_OFF, ST_DISABLED: state <= ST_SOFT_START;
                ST_SOFT_START: begin
                    if (oc_flag) begin
                        state <= ST_SOFT_STOP;
                    end else begin
                        level <= lvl_up;
                        if (lvl_up == LVL_MAX) state <= ST_RUN;
                    end
                end
                ST_RUN: if (oc_flag) state <= ST_SOFT_STOP;
                ST_SOFT_STOP: begin
                    if (level < FLOOR_V) state <= ST_SOFT_START;
                    else                 level <= lvl_dn;
                end
                default: begin
                    state <= ST_OFF;
                    level <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/soft_start_seq.sv
// Top of the soft-start and fault shutdown sequencer.
// Combines supply hysteresis, no-load hysteresis, the sequencer core,
// and the duty clamp that feeds the PWM generator.
// Assumes: all inputs are synchronous to clk.
module soft_start_seq
    import ss_seq_pkg::*;
#(
    parameter int SUP_W    = 8,
    parameter int LVL_W    = 8,
    parameter int STEP_W   = 4,
    parameter int UV_START = 110,
    parameter int UV_STOP  = 90,
    parameter int NL_ON    = 31,
    parameter int NL_OFF   = 26,
    parameter int FAST_MUL = 10,
    parameter int FLOOR    = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUP_W-1:0]  sup_lvl,
    input  logic              ref_ok,
    input  logic              dis_req,
    input  logic              oc_flag,
    input  logic [STEP_W-1:0] step,
    input  logic [LVL_W-1:0]  duty_in,
    output logic [2:0]        state_o,
    output logic [LVL_W-1:0]  level_o,
    output logic [LVL_W-1:0]  duty_o,
    output logic              out_en
);
    logic       uv_ok;
    logic       nl_ok;
    logic       pwr_ok;
    seq_state_e st;

    ss_hyst #(.W(SUP_W), .SET_TH(UV_START), .CLR_TH(UV_STOP)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .val(sup_lvl), .on(uv_ok)
    );

    ss_hyst #(.W(LVL_W), .SET_TH(NL_ON + 1), .CLR_TH(NL_OFF)) u_noload (
        .clk(clk), .rst_n(rst_n), .val(duty_in), .on(nl_ok)
    );

    assign pwr_ok = uv_ok & ref_ok;

    ss_seq_core #(
        .LVL_W(LVL_W), .STEP_W(STEP_W), .FAST_MUL(FAST_MUL), .FLOOR(FLOOR)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .dis_req(dis_req),
        .oc_flag(oc_flag), .step(step), .state(st), .level(level_o)
    );

    // Clamp the duty command and gate the enable by state and load.
    always_comb begin
        duty_o  = (duty_in < level_o) ? duty_in : level_o;
        out_en  = nl_ok && ((st == ST_SOFT_START) || (st == ST_RUN));
        state_o = st;
    end
endmodule

// File: rtl/soft_start_seq_chk.sv
// Property checker for soft_start_seq, attached with bind below.
// Assumes: state codes from ss_seq_pkg.
module soft_start_seq_chk
    import ss_seq_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_ok,
    input logic             uv_ok,
    input logic             dis_req,
    input logic             oc_flag,
    input logic [LVL_W-1:0] duty_in,
    input logic [2:0]       state_o,
    input logic [LVL_W-1:0] level_o,
    input logic [LVL_W-1:0] duty_o,
    input logic             out_en
);
    p_refloss_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |=> (state_o == ST_OFF && level_o == '0));

    p_dis_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> (level_o == '0));

    p_ramp_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SOFT_START && $past(state_o) == ST_SOFT_START)
            |-> (level_o >= $past(level_o)));

    p_oc_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && ref_ok && uv_ok && !dis_req && state_o == ST_RUN)
            |=> (state_o == ST_SOFT_STOP && level_o == $past(level_o)));

    p_stop_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SOFT_STOP && $past(state_o) == ST_SOFT_STOP)
            |-> (level_o <= $past(level_o)));

    p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_o <= level_o) && (duty_o <= duty_in)
            && ((duty_o == level_o) || (duty_o == duty_in)));

    p_en_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (state_o == ST_SOFT_START || state_o == ST_RUN));
endmodule

bind soft_start_seq soft_start_seq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .uv_ok(uv_ok),
    .dis_req(dis_req), .oc_flag(oc_flag), .duty_in(duty_in),
    .state_o(state_o), .level_o(level_o), .duty_o(duty_o), .out_en(out_en)
);

// File: tb/soft_start_seq_tb.sv
`timescale 1ns/1ps
module soft_start_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sup_lvl = '0;
    logic       ref_ok = 1'b1;
    logic       dis_req = 1'b0;
    logic       oc_flag = 1'b0;
    logic [3:0] step = 4'd5;
    logic [7:0] duty_in = 8'd200;
    logic [2:0] state_o;
    logic [7:0] level_o, duty_o;
    logic       out_en;

    int n_chk = 0;
    int n_fail = 0;
    bit nl_m = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    soft_start_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sup_lvl(sup_lvl), .ref_ok(ref_ok),
        .dis_req(dis_req), .oc_flag(oc_flag), .step(step), .duty_in(duty_in),
        .state_o(state_o), .level_o(level_o), .duty_o(duty_o), .out_en(out_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock; the no-load model follows R10 on the same edge.
    task automatic tick();
        @(posedge clk);
        if (rst_n) begin
            if (!nl_m && duty_in > 8'd31)      nl_m = 1'b1;
            else if (nl_m && duty_in < 8'd26) nl_m = 1'b0;
        end
        #1;
    endtask

    task automatic restart();
        dis_req = 1'b1; tick();
        chk("R4 disabled state", int'(state_o), 4);
        chk("R4 disabled level", int'(level_o), 0);
        chk("R4 disabled enable", int'(out_en), 0);
        dis_req = 1'b0; tick();
        chk("R4 release state", int'(state_o), 1);
        chk("R4 release level", int'(level_o), 0);
    endtask

    task automatic ramp();
        for (int k = 1; k <= 300; k++) begin
            int e;
            tick();
            e = (k * int'(step) > 255) ? 255 : k * int'(step);
            chk("R5 ramp level", int'(level_o), e);
            chk("R5 ramp state", int'(state_o), (e == 255) ? 2 : 1);
            chk("R9 ramp clamp", int'(duty_o), (int'(duty_in) < e) ? int'(duty_in) : e);
            chk("R10 ramp enable", int'(out_en), int'(nl_m));
            if (e == 255) break;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        chk("R1 reset state", int'(state_o), 0);
        chk("R1 reset level", int'(level_o), 0);
        chk("R1 reset duty", int'(duty_o), 0);
        chk("R1 reset enable", int'(out_en), 0);
        rst_n = 1'b1;
        chk("R1 post-reset state", int'(state_o), 0);

        // R2: every supply code below start keeps OFF.
        for (int v = 0; v < 110; v++) begin
            sup_lvl = 8'(v); tick();
            chk("R2 below start", int'(state_o), 0);
            chk("R3 off level", int'(level_o), 0);
        end
        sup_lvl = 8'd110; tick();
        chk("R2 flag latency", int'(state_o), 0);
        tick();
        chk("R3 off to soft start", int'(state_o), 1);
        chk("R3 soft start level", int'(level_o), 0);

        // R5: ramp sweep over every nonzero step.
        for (int s = 1; s < 16; s++) begin
            step = 4'(s);
            restart();
            ramp();
        end

        // R6/R7: soft stop sweep over every nonzero step.
        for (int s = 1; s < 16; s++) begin
            int prev;
            step = 4'd15; restart(); ramp();
            step = 4'(s); oc_flag = 1'b1; tick();
            chk("R6 enter stop", int'(state_o), 3);
            chk("R6 level held", int'(level_o), 255);
            chk("R10 stop enable", int'(out_en), 0);
            prev = 255;
            while (prev >= 26) begin
                int e;
                tick();
                e = (prev >= 10 * s) ? prev - 10 * s : 0;
                chk("R7 stop level", int'(level_o), e);
                chk("R7 oc ignored", int'(state_o), 3);
                prev = e;
            end
            oc_flag = 1'b0; tick();
            chk("R7 restart state", int'(state_o), 1);
            chk("R7 restart level", int'(level_o), prev);
            tick();
            chk("R5 after stop", int'(level_o), (prev + s > 255) ? 255 : prev + s);
        end

        // R6/R7: overcurrent during soft start.
        step = 4'd5; restart();
        tick(); tick(); tick();
        chk("R5 partial ramp", int'(level_o), 15);
        oc_flag = 1'b1; tick();
        chk("R6 stop from ramp", int'(state_o), 3);
        chk("R6 level kept", int'(level_o), 15);
        oc_flag = 1'b0; tick();
        chk("R7 below floor", int'(state_o), 1);
        chk("R7 below floor level", int'(level_o), 15);

        // R2/R3: supply hysteresis from RUN.
        step = 4'd15; restart(); ramp();
        sup_lvl = 8'd90;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 at stop threshold", int'(state_o), 2);
        end
        sup_lvl = 8'd89; tick();
        chk("R2 flag latency drop", int'(state_o), 2);
        tick();
        chk("R3 supply loss state", int'(state_o), 0);
        chk("R3 supply loss level", int'(level_o), 0);
        sup_lvl = 8'd100;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 dead band", int'(state_o), 0);
        end
        sup_lvl = 8'd110; tick(); tick();
        chk("R2 restart", int'(state_o), 1);

        // R8: simultaneous conditions.
        ramp();
        dis_req = 1'b1; oc_flag = 1'b1; tick();
        chk("R8 disable over oc", int'(state_o), 4);
        chk("R8 disable level", int'(level_o), 0);
        ref_ok = 1'b0; tick();
        chk("R8 ref over disable", int'(state_o), 0);
        ref_ok = 1'b1; dis_req = 1'b0; oc_flag = 1'b0; tick();
        chk("R3 ref recovered", int'(state_o), 1);
        ramp();
        ref_ok = 1'b0; tick();
        chk("R3 ref loss state", int'(state_o), 0);
        chk("R3 ref loss level", int'(level_o), 0);
        ref_ok = 1'b1; tick();
        chk("R3 ref back", int'(state_o), 1);

        // R11: zero step holds the level.
        restart();
        step = 4'd0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R11 zero step level", int'(level_o), 0);
            chk("R11 zero step state", int'(state_o), 1);
        end
        step = 4'd3; tick();
        chk("R11 step resumes", int'(level_o), 3);

        // R9/R10: duty sweep down then up in RUN.
        step = 4'd15; restart(); ramp();
        for (int d = 200; d >= 0; d--) begin
            duty_in = 8'(d); tick();
            chk("R10 no-load down", int'(out_en), int'(nl_m));
            chk("R9 pass-through", int'(duty_o), d);
        end
        for (int d = 0; d < 256; d++) begin
            duty_in = 8'(d); tick();
            chk("R10 no-load up", int'(out_en), int'(nl_m));
            chk("R9 pass-through up", int'(duty_o), d);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule